// File: doc/BRIEF.md
# Precise Exception Entry Sequencer

This block decides when an in-order core leaves its normal flow and enters an interrupt handler. It looks only at the oldest entry of the completion queue. When that entry has finished execution and carries a fault, or when an external request is pending and allowed, the block recognizes the exception in that cycle. The entry is then not retired.

From the next cycle on, a fixed timeline runs. The pipeline is killed for one cycle. A one-cycle redirect strobe carries the handler address, which is a base plus a per-cause stride. The faulting instruction pointer and the machine state word are copied into two save registers, and the interrupt-enable and recoverable bits are cleared. A restore-complete flag rises within three clocks of recognition. The sequencer stays busy until the core reports that the handler's first instruction has issued. Until then, any further exception stays pending.

Software controls the two live state bits through three write-only command codes. Each code loads a fixed pair of values into the bits.

Top module: `exc_entry_seq`

## Requirements
- R1: An exception is recognized (`recognize` high, combinationally) only in a cycle where `hq_valid` and `hq_done` are both high and the sequencer is idle (`busy` low).
- R2: An idle, valid, completed head with `hq_fault` low is retired (`retire` high) unless an external request is taken in that cycle. `retire` and `recognize` are never high together.
- R3: An external request (`ext_irq` high at a valid, completed, non-faulting head) is taken only while `msr_ee` is 1. A synchronous fault is taken whatever the value of `msr_ee`.
- R4: In the cycle after recognition, `flush` and `redirect_valid` are high for exactly one cycle.
- R5: `redirect_addr` is `VEC_BASE + cause * 2^VEC_SHIFT`. The cause is `hq_cause` for a fault and `EXT_CAUSE` (default 5) for an external request. Defaults: base 0x1000, shift 8.
- R6: On recognition, `srr0` takes `hq_pc` and `srr1` takes the state word as it was before entry. The state word holds `msr_ee` at bit 1 and `msr_ri` at bit 0, with all other bits 0. Both values are visible from the cycle after recognition.
- R7: On entry, `msr_ee` and `msr_ri` are both cleared in the cycle after recognition. Entry takes precedence over a command write at the same edge.
- R8: `restore_done` rises exactly 3 cycles after recognition and stays high while `busy`.
- R9: When `port_wr` is high, `port_sel` selects the new bit values from the next cycle. Code 0 gives EE=1 and RI=1. Code 1 gives EE=0 and RI=1. Code 2 gives EE=0 and RI=0. Code 3 changes nothing.
- R10: While `busy`, no new exception is recognized and no head is retired. `busy` falls in the cycle after `first_issue` is seen together with `restore_done`.
- R11: After reset, `busy`, `flush`, `redirect_valid`, `restore_done`, `msr_ee`, `msr_ri`, `srr0` and `srr1` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hq_valid | input | 1 | Oldest completion-queue entry is present |
| hq_done | input | 1 | Oldest entry has finished execution |
| hq_fault | input | 1 | Oldest entry raised a synchronous exception |
| hq_cause | input | CAUSE_W | Cause code of the oldest entry's fault |
| hq_pc | input | XLEN | Instruction pointer of the oldest entry |
| ext_irq | input | 1 | External interrupt request (level) |
| port_wr | input | 1 | Write strobe for the state-bit command port |
| port_sel | input | 2 | Command code: 0 enable, 1 disable-external, 2 non-recoverable |
| first_issue | input | 1 | Core has issued the handler's first instruction |
| retire | output | 1 | Oldest entry retires this cycle |
| recognize | output | 1 | Exception recognized this cycle |
| flush | output | 1 | Kill the pipeline |
| redirect_valid | output | 1 | One-cycle strobe for the redirect address |
| redirect_addr | output | XLEN | Handler address |
| restore_done | output | 1 | Pre-fault state fully restored |
| busy | output | 1 | Entry sequence in progress |
| srr0 | output | XLEN | Saved instruction pointer |
| srr1 | output | MSR_W | Saved state word |
| msr_ee | output | 1 | External-interrupt enable bit |
| msr_ri | output | 1 | Recoverable-interrupt bit |

## Verification
The assertions rely on three properties of the core's inputs. `hq_done` is only meaningful together with `hq_valid`. `first_issue` is raised only once the handler has actually been fetched, so never before `restore_done`. The head entry's fields stay stable while it is presented. The bench drives each head for exactly one idle cycle and withdraws it at recognition, except in the hold test, where the fault deliberately remains asserted through the busy window. It pulses `first_issue` only after it has seen `restore_done`.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_KILL    = 2'd1,
    ST_RECOVER = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_ENABLE  = 2'd0,
    CMD_EXT_OFF = 2'd1,
    CMD_NONREC  = 2'd2,
    CMD_NOP     = 2'd3
  } bit_cmd_e;

  // Handler address: base plus cause shifted by the per-cause stride.
  function automatic logic [63:0] vec_addr(input logic [63:0] base,
                                           input logic [7:0]  cause,
                                           input int unsigned shift);
    return base + (64'(cause) << shift);
  endfunction

endpackage

// File: rtl/exc_state_bits.sv
module exc_state_bits
  import exc_pkg::*;
#(
  parameter int MSR_W  = 8,
  parameter int EE_BIT = 1,
  parameter int RI_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_wr,
  input  logic [1:0]       port_sel,
  input  logic             entry_clr,
  output logic             ee,
  output logic             ri,
  output logic [MSR_W-1:0] msr_word
);

  logic cmd_hit;
  logic ee_nxt, ri_nxt;

  always_comb begin
    cmd_hit = port_wr && (bit_cmd_e'(port_sel) != CMD_NOP);
    ee_nxt  = ee;
    ri_nxt  = ri;
    if (entry_clr) begin
      ee_nxt = 1'b0;
      ri_nxt = 1'b0;
    end else if (cmd_hit) begin
      unique case (bit_cmd_e'(port_sel))
        CMD_ENABLE:  begin ee_nxt = 1'b1; ri_nxt = 1'b1; end
        CMD_EXT_OFF: begin ee_nxt = 1'b0; ri_nxt = 1'b1; end
        CMD_NONREC:  begin ee_nxt = 1'b0; ri_nxt = 1'b0; end
        default:     begin ee_nxt = ee;   ri_nxt = ri;   end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ee <= 1'b0;
      ri <= 1'b0;
    end else begin
      ee <= ee_nxt;
      ri <= ri_nxt;
    end
  end

  always_comb begin
    msr_word         = '0;
    msr_word[EE_BIT] = ee;
    msr_word[RI_BIT] = ri;
  end

  // R7
  entry_clears_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_clr |=> (!ee && !ri));

  // R9
  cmd_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && port_sel == 2'd0 && !entry_clr) |=> (ee && ri));

  // R9
  cmd_nonrec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && port_sel == 2'd2 && !entry_clr) |=> (!ee && !ri));

  // R9
  cmd_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && port_sel == 2'd3 && !entry_clr) |=> ($stable(ee) && $stable(ri)));

endmodule

// File: rtl/exc_save_regs.sv
module exc_save_regs #(
  parameter int XLEN  = 32,
  parameter int MSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [MSR_W-1:0] msr_in,
  output logic [XLEN-1:0]  srr0,
  output logic [MSR_W-1:0] srr1
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srr0 <= '0;
      srr1 <= '0;
    end else if (capture) begin
      srr0 <= pc_in;
      srr1 <= msr_in;
    end
  end

  // R6
  save_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (srr0 == $past(pc_in)));

  // R6
  save_msr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (srr1 == $past(msr_in)));

endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
  import exc_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          CAUSE_W     = 3,
  parameter logic [63:0] VEC_BASE    = 64'h1000,
  parameter int          VEC_SHIFT   = 8,
  parameter int          EXT_CAUSE   = 5,
  parameter int          RESTORE_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hq_valid,
  input  logic               hq_done,
  input  logic               hq_fault,
  input  logic [CAUSE_W-1:0] hq_cause,
  input  logic               ext_irq,
  input  logic               ee,
  input  logic               first_issue,
  output logic               recognize,
  output logic               retire,
  output logic               flush,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_addr,
  output logic               restore_done,
  output logic               busy
);

  localparam int CNT_W = $clog2(RESTORE_CYC + 1);

  seq_state_e         state, state_nxt;
  logic [CNT_W-1:0]   cnt;
  logic               head_ready, take_sync, take_ext;
  logic [7:0]         sel_cause;
  logic               leave;

  always_comb begin
    busy       = (state != ST_IDLE);
    head_ready = !busy && hq_valid && hq_done;
    take_sync  = head_ready && hq_fault;
    take_ext   = head_ready && !hq_fault && ext_irq && ee;
    recognize  = take_sync || take_ext;
    retire     = head_ready && !recognize;
    sel_cause  = take_sync ? 8'(hq_cause) : 8'(EXT_CAUSE);
    flush      = (state == ST_KILL);
    restore_done = busy && (cnt >= CNT_W'(RESTORE_CYC));
    leave      = restore_done && first_issue;
  end

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:    if (recognize) state_nxt = ST_KILL;
      ST_KILL:    state_nxt = leave ? ST_IDLE : ST_RECOVER;
      ST_RECOVER: if (leave) state_nxt = ST_IDLE;
      default:    state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      cnt            <= '0;
      redirect_valid <= 1'b0;
      redirect_addr  <= '0;
    end else begin
      state          <= state_nxt;
      redirect_valid <= recognize;
      if (recognize) begin
        cnt           <= CNT_W'(1);
        redirect_addr <= XLEN'(vec_addr(VEC_BASE, sel_cause, VEC_SHIFT));
      end else if (busy && cnt < CNT_W'(RESTORE_CYC)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1
  recog_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recognize |-> (hq_valid && hq_done && !busy));

  // R2
  retire_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire && recognize));

  // R3
  ext_needs_ee_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recognize && !hq_fault) |-> ee);

  // R4
  kill_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recognize |=> (flush && redirect_valid));

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);

  // R8
  restore_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ##1 restore_done);

  // R10
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!recognize && !retire));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          CAUSE_W     = 3,
  parameter int          MSR_W       = 8,
  parameter int          EE_BIT      = 1,
  parameter int          RI_BIT      = 0,
  parameter logic [63:0] VEC_BASE    = 64'h1000,
  parameter int          VEC_SHIFT   = 8,
  parameter int          EXT_CAUSE   = 5,
  parameter int          RESTORE_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hq_valid,
  input  logic               hq_done,
  input  logic               hq_fault,
  input  logic [CAUSE_W-1:0] hq_cause,
  input  logic [XLEN-1:0]    hq_pc,
  input  logic               ext_irq,
  input  logic               port_wr,
  input  logic [1:0]         port_sel,
  input  logic               first_issue,
  output logic               retire,
  output logic               recognize,
  output logic               flush,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_addr,
  output logic               restore_done,
  output logic               busy,
  output logic [XLEN-1:0]    srr0,
  output logic [MSR_W-1:0]   srr1,
  output logic               msr_ee,
  output logic               msr_ri
);

  logic [MSR_W-1:0] msr_word;

  exc_state_bits #(
    .MSR_W (MSR_W),
    .EE_BIT(EE_BIT),
    .RI_BIT(RI_BIT)
  ) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_wr  (port_wr),
    .port_sel (port_sel),
    .entry_clr(recognize),
    .ee       (msr_ee),
    .ri       (msr_ri),
    .msr_word (msr_word)
  );

  exc_entry_fsm #(
    .XLEN       (XLEN),
    .CAUSE_W    (CAUSE_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_SHIFT  (VEC_SHIFT),
    .EXT_CAUSE  (EXT_CAUSE),
    .RESTORE_CYC(RESTORE_CYC)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .hq_valid      (hq_valid),
    .hq_done       (hq_done),
    .hq_fault      (hq_fault),
    .hq_cause      (hq_cause),
    .ext_irq       (ext_irq),
    .ee            (msr_ee),
    .first_issue   (first_issue),
    .recognize     (recognize),
    .retire        (retire),
    .flush         (flush),
    .redirect_valid(redirect_valid),
    .redirect_addr (redirect_addr),
    .restore_done  (restore_done),
    .busy          (busy)
  );

  exc_save_regs #(
    .XLEN (XLEN),
    .MSR_W(MSR_W)
  ) u_save (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(recognize),
    .pc_in  (hq_pc),
    .msr_in (msr_word),
    .srr0   (srr0),
    .srr1   (srr1)
  );

endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hq_valid = 0, hq_done = 0, hq_fault = 0, ext_irq = 0;
  logic [2:0]  hq_cause = 0;
  logic [31:0] hq_pc = 0;
  logic        port_wr = 0, first_issue = 0;
  logic [1:0]  port_sel = 0;
  logic        retire, recognize, flush, redirect_valid, restore_done, busy;
  logic [31:0] redirect_addr, srr0;
  logic [7:0]  srr1;
  logic        msr_ee, msr_ri;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .hq_valid(hq_valid), .hq_done(hq_done),
    .hq_fault(hq_fault), .hq_cause(hq_cause), .hq_pc(hq_pc), .ext_irq(ext_irq),
    .port_wr(port_wr), .port_sel(port_sel), .first_issue(first_issue),
    .retire(retire), .recognize(recognize), .flush(flush),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .restore_done(restore_done), .busy(busy), .srr0(srr0), .srr1(srr1),
    .msr_ee(msr_ee), .msr_ri(msr_ri)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] handler_at(input int c);
    return 32'h1000 + c * 256;
  endfunction

  task automatic write_cmd(input logic [1:0] sel);
    @(negedge clk);
    port_wr = 1; port_sel = sel;
    @(negedge clk);
    port_wr = 0;
  endtask

  // Presents a head for one idle cycle, expects entry, and walks the timeline.
  task automatic enter(input bit is_fault, input int cause, input logic [31:0] pc,
                       input int exp_cause);
    logic [7:0] msr_before;
    @(negedge clk);
    msr_before = {6'b0, msr_ee, msr_ri};
    hq_valid = 1; hq_done = 1; hq_fault = is_fault; hq_cause = 3'(cause);
    hq_pc = pc; ext_irq = !is_fault;
    #1;
    chk("R1 recognize", recognize, 1);
    chk("R2 no retire on entry", retire, 0);
    @(negedge clk);
    hq_valid = 0; hq_done = 0; hq_fault = 0; ext_irq = 0;
    chk("R4 flush", flush, 1);
    chk("R4 redirect_valid", redirect_valid, 1);
    chk("R5 redirect_addr", redirect_addr, handler_at(exp_cause));
    chk("R6 srr0", srr0, pc);
    chk("R6 srr1", 32'(srr1), 32'(msr_before));
    chk("R7 ee/ri cleared", {msr_ee, msr_ri}, 0);
    chk("R8 not yet restored", restore_done, 0);
    @(negedge clk);
    chk("R4 flush one cycle", {flush, redirect_valid}, 0);
    chk("R8 not yet restored T+2", restore_done, 0);
    @(negedge clk);
    chk("R8 restore_done at T+3", restore_done, 1);
    chk("R10 busy", busy, 1);
    first_issue = 1;
    @(negedge clk);
    first_issue = 0;
    chk("R10 busy falls", busy, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 flush/redirect", {flush, redirect_valid, restore_done}, 0);
    chk("R11 msr", {msr_ee, msr_ri}, 0);
    chk("R11 srr0", srr0, 0);
    chk("R11 srr1", 32'(srr1), 0);
    rst_n = 1;

    // R9 sweep of all command codes from every starting pair
    for (int start = 0; start < 3; start++) begin
      for (int s = 0; s < 4; s++) begin
        logic e0, r0;
        write_cmd(2'(start));
        e0 = msr_ee; r0 = msr_ri;
        write_cmd(2'(s));
        if (s == 3) chk("R9 code 3 no change", {msr_ee, msr_ri}, {e0, r0});
        else chk("R9 command", {msr_ee, msr_ri}, {s == 0, s != 2});
      end
    end

    // R2 retire plain head
    @(negedge clk);
    hq_valid = 1; hq_done = 1;
    #1;
    chk("R2 retire", retire, 1);
    chk("R1 no recognize", recognize, 0);
    hq_done = 0;
    #1;
    chk("R1 not done, no retire", {retire, recognize}, 0);
    hq_valid = 0;

    // R3 external ignored when EE=0
    write_cmd(2'd1);
    @(negedge clk);
    hq_valid = 1; hq_done = 1; ext_irq = 1;
    #1;
    chk("R3 ext blocked", recognize, 0);
    chk("R3 head retires", retire, 1);
    @(negedge clk);
    hq_valid = 0; hq_done = 0; ext_irq = 0;
    chk("R3 no flush", flush, 0);

    // R3/R5/R6 sync faults over every cause with EE=0 and EE=1
    for (int c = 0; c < 8; c++) begin
      write_cmd((c % 2) ? 2'd0 : 2'd1);
      enter(1, c, 32'h400 + c * 4, c);
    end

    // R3 external taken with EE=1, cause fixed at 5
    write_cmd(2'd0);
    enter(0, 2, 32'hABC0, 5);

    // R7 entry beats simultaneous command
    write_cmd(2'd2);
    @(negedge clk);
    hq_valid = 1; hq_done = 1; hq_fault = 1; hq_cause = 1; hq_pc = 32'h88;
    port_wr = 1; port_sel = 2'd0;
    @(negedge clk);
    port_wr = 0;
    chk("R7 entry wins", {msr_ee, msr_ri}, 0);
    // R10 fault still held at head: not recognized while busy
    #1;
    chk("R10 hold", {recognize, retire}, 0);
    hq_pc = 32'h99;
    repeat (2) @(negedge clk);
    chk("R10 still held", recognize, 0);
    first_issue = 1;
    @(negedge clk);
    first_issue = 0;
    #1;
    chk("R10 pending taken after issue", recognize, 1);
    @(negedge clk);
    hq_valid = 0; hq_done = 0; hq_fault = 0;
    chk("R6 second srr0", srr0, 32'h99);
    repeat (2) @(negedge clk);
    first_issue = 1;
    @(negedge clk);
    first_issue = 0;
    chk("R10 idle again", busy, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule